// File: doc/BRIEF.md
# Write Unlock and Block Lock Gate

This block stands in front of an 8 KB nonvolatile array and decides, for each write strobe, whether the write reaches the array. A write is only honoured after a three-write key sequence has armed the gate. The third write of that sequence carries a command byte. One command opens a data burst. The other arms a one-shot load of an 8-bit lock map, in which each bit shields one 1 KB region. An external write-allow pin must also be high for any data write or lock-map load to take effect.

Every strobe produces exactly one registered outcome on the next clock. A data write that gets through raises `arr_we`. A write that is refused raises `wr_reject`. Key writes that match the sequence raise neither. A burst ends after `PAGE_MAX` data writes, or after a pause of `GAP_LIMIT` strobe-free cycles. Either ending returns the gate to idle, so the next write needs a new key sequence.

Top module: `nvm_write_gate`

## Requirements
- R1: After reset both outputs are low, the lock map is all zero and the gate is idle: an unkeyed write is refused, and a keyed write to any block goes through.
- R2: The key sequence is 0xAA to address 0x1555, then 0x55 to address 0x0AAA, then a command byte to address 0x1555. Matching key writes raise neither `arr_we` nor `wr_reject`.
- R3: A write that arrives while the gate is idle and is not the first key write is refused (`wr_reject` high for one cycle, `arr_we` low).
- R4: A write that does not match the expected key step, including an unknown command byte (anything but 0xA0 or 0xC0), is refused and returns the gate to idle. The sequence must then restart from its first step.
- R5: After command 0xA0, a data write to an unlocked block with `wr_allow` high raises `arr_we` for exactly the cycle after its strobe.
- R6: The lock bit checked for a data write is the one indexed by address bits 12..10. A data write to a block whose bit is 1 is refused.
- R7: After command 0xC0, the next write with `wr_allow` high loads its data byte into the lock map (bit i guards block i) and raises neither output. The value 0xFF locks every block.
- R8: With `wr_allow` low, data writes and lock-map loads are refused and leave the lock map unchanged. Key writes are still accepted.
- R9: A data burst ends after `PAGE_MAX` writes. The next write is refused unless it starts a new sequence.
- R10: In any non-idle state, `GAP_LIMIT` consecutive cycles without a strobe return the gate to idle. Shorter pauses keep the state.
- R11: `arr_we` and `wr_reject` are never high together, and either one is high only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write request |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wr_allow | input | 1 | Hardware write-allow, high permits data writes and lock loads |
| arr_we | output | 1 | Registered write enable toward the array |
| wr_reject | output | 1 | Registered flag for a refused write |

## Verification
A corrupt sequence state shows up on the very next strobe as a wrong outcome: a key write refused, a data write let through without a key, or a refusal where `arr_we` was due. A wrong lock bit stays hidden until a data write hits that block, so the stimulus probes block edges and every block after loading sparse, empty and full maps. A wrong burst or pause counter is only seen at the boundary write. For that reason, burst lengths and pauses are run exactly at the limit and one short of it.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = 13'h1555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = 13'h0AAA;
  localparam logic [DATA_W-1:0] KEY_BYTE_1 = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_BYTE_2 = 8'h55;
  localparam logic [DATA_W-1:0] CMD_OPEN   = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_LOCKLD = 8'hC0;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_DATA,
    SQ_PROT
  } seq_e;

  function automatic logic key_hit(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                                   input logic [ADDR_W-1:0] ea, input logic [DATA_W-1:0] ed);
    return (a == ea) && (d == ed);
  endfunction
endpackage

// File: rtl/wg_seq_tracker.sv
module wg_seq_tracker
  import wg_pkg::*;
#(
  parameter int PAGE_MAX  = 32,
  parameter int GAP_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output seq_e              state,
  output logic              seq_accept,
  output logic              burst_done,
  output logic              gap_expire
);
  localparam int PW = (PAGE_MAX > 1) ? $clog2(PAGE_MAX) : 1;
  localparam int GW = (GAP_LIMIT > 1) ? $clog2(GAP_LIMIT) : 1;
  localparam logic [PW-1:0] PAGE_LAST = PW'(PAGE_MAX - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(GAP_LIMIT - 1);

  seq_e          st_q, st_n;
  logic [PW-1:0] page_q, page_n;
  logic [GW-1:0] gap_q, gap_n;

  always_comb begin
    st_n       = st_q;
    page_n     = page_q;
    gap_n      = gap_q;
    seq_accept = 1'b0;
    burst_done = 1'b0;
    gap_expire = 1'b0;
    if (stb) begin
      gap_n = '0;
      unique case (st_q)
        SQ_IDLE: if (key_hit(addr, data, KEY_ADDR_A, KEY_BYTE_1)) begin
          st_n = SQ_KEY1; seq_accept = 1'b1;
        end
        SQ_KEY1: if (key_hit(addr, data, KEY_ADDR_B, KEY_BYTE_2)) begin
          st_n = SQ_KEY2; seq_accept = 1'b1;
        end else st_n = SQ_IDLE;
        SQ_KEY2: if (key_hit(addr, data, KEY_ADDR_A, CMD_OPEN)) begin
          st_n = SQ_DATA; seq_accept = 1'b1;
        end else if (key_hit(addr, data, KEY_ADDR_A, CMD_LOCKLD)) begin
          st_n = SQ_PROT; seq_accept = 1'b1;
        end else st_n = SQ_IDLE;
        SQ_DATA: if (page_q == PAGE_LAST) begin
          st_n = SQ_IDLE; burst_done = 1'b1;
        end else page_n = page_q + PW'(1);
        SQ_PROT: st_n = SQ_IDLE;
        default: st_n = SQ_IDLE;
      endcase
    end else if (st_q != SQ_IDLE) begin
      if (gap_q == GAP_LAST) begin
        st_n = SQ_IDLE; gap_expire = 1'b1;
      end else gap_n = gap_q + GW'(1);
    end
    if (st_n != SQ_DATA) page_n = '0;
    if (st_n == SQ_IDLE) gap_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      page_q <= '0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_n;
      page_q <= page_n;
      gap_q  <= gap_n;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/wg_lock_map.sv
module wg_lock_map #(
  parameter int N_BLK = 8,
  parameter int BLK_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_BLK-1:0] din,
  input  logic [BLK_W-1:0] idx,
  output logic             locked,
  output logic [N_BLK-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= din;
  end

  assign locked = q[idx];
endmodule

// File: rtl/nvm_write_gate.sv
module nvm_write_gate
  import wg_pkg::*;
#(
  parameter int PAGE_MAX  = 32,
  parameter int GAP_LIMIT = 4,
  parameter int N_BLK     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_allow,
  output logic              arr_we,
  output logic              wr_reject
);
  localparam int BLK_W = $clog2(N_BLK);

  seq_e             seq_state;
  logic             seq_accept, burst_done, gap_expire;
  logic             seq_idle, data_phase, prot_phase;
  logic             blk_locked, prot_load;
  logic [N_BLK-1:0] prot_q;
  logic [BLK_W-1:0] blk_idx;
  logic             we_d, rej_d;

  wg_seq_tracker #(.PAGE_MAX(PAGE_MAX), .GAP_LIMIT(GAP_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .stb(wr_stb), .addr(wr_addr), .data(wr_data),
    .state(seq_state), .seq_accept(seq_accept), .burst_done(burst_done),
    .gap_expire(gap_expire)
  );

  assign blk_idx    = wr_addr[ADDR_W-1 -: BLK_W];
  assign seq_idle   = (seq_state == SQ_IDLE);
  assign data_phase = (seq_state == SQ_DATA);
  assign prot_phase = (seq_state == SQ_PROT);
  assign prot_load  = wr_stb && prot_phase && wr_allow;

  wg_lock_map #(.N_BLK(N_BLK), .BLK_W(BLK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(prot_load), .din(wr_data[N_BLK-1:0]),
    .idx(blk_idx), .locked(blk_locked), .q(prot_q)
  );

  assign we_d  = wr_stb && data_phase && wr_allow && !blk_locked;
  assign rej_d = wr_stb && !we_d && !prot_load && !seq_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we    <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      arr_we    <= we_d;
      wr_reject <= rej_d;
    end
  end
endmodule

// File: rtl/wg_checker.sv
module wg_checker #(
  parameter int N_BLK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             wr_allow,
  input logic [7:0]       wr_data,
  input logic             arr_we,
  input logic             wr_reject,
  input logic             seq_idle,
  input logic             data_phase,
  input logic             prot_phase,
  input logic             seq_accept,
  input logic             blk_locked,
  input logic             prot_load,
  input logic             burst_done,
  input logic             gap_expire,
  input logic [N_BLK-1:0] prot_q
);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && wr_reject));
  assert_after_stb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || wr_reject) |-> $past(wr_stb));
  assert_key_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept |=> (!arr_we && !wr_reject));
  assert_unkeyed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !seq_accept && !data_phase && !prot_phase) |=> wr_reject);
  assert_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && data_phase && blk_locked) |=> (wr_reject && !arr_we));
  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_load |=> (prot_q == $past(wr_data[N_BLK-1:0])));
  assert_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_allow && (data_phase || prot_phase)) |=> (!arr_we && $stable(prot_q)));
  assert_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> seq_idle);
  assert_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_expire |=> seq_idle);
endmodule

bind nvm_write_gate wg_checker #(.N_BLK(N_BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_allow(wr_allow), .wr_data(wr_data),
  .arr_we(arr_we), .wr_reject(wr_reject), .seq_idle(seq_idle), .data_phase(data_phase),
  .prot_phase(prot_phase), .seq_accept(seq_accept), .blk_locked(blk_locked),
  .prot_load(prot_load), .burst_done(burst_done), .gap_expire(gap_expire), .prot_q(prot_q)
);

// File: tb/sim_nvm_write_gate.sv
module sim_nvm_write_gate;
  localparam int PAGE_MAX  = 32;
  localparam int GAP_LIMIT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_allow = 1'b1;
  logic        arr_we, wr_reject;

  always #2 clk = ~clk;

  nvm_write_gate #(.PAGE_MAX(PAGE_MAX), .GAP_LIMIT(GAP_LIMIT), .N_BLK(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_allow(wr_allow), .arr_we(arr_we), .wr_reject(wr_reject)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    started = 0;

  // behavioural reference: 0 idle, 1 first key seen, 2 second key seen, 3 burst, 4 lock load
  int       ms = 0, mgap = 0, mcnt = 0;
  logic [7:0] mprot = '0;
  logic     exp_we = 1'b0, exp_rej = 1'b0;

  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (!rst_n) begin
      ms = 0; mgap = 0; mcnt = 0; mprot = '0; exp_we = 0; exp_rej = 0;
    end else begin
      exp_we = 0; exp_rej = 0;
      if (wr_stb) begin
        mgap = 0;
        case (ms)
          0: if (wr_addr == 13'h1555 && wr_data == 8'hAA) ms = 1; else exp_rej = 1;
          1: if (wr_addr == 13'h0AAA && wr_data == 8'h55) ms = 2;
             else begin exp_rej = 1; ms = 0; end
          2: if (wr_addr == 13'h1555 && wr_data == 8'hA0) begin ms = 3; mcnt = 0; end
             else if (wr_addr == 13'h1555 && wr_data == 8'hC0) ms = 4;
             else begin exp_rej = 1; ms = 0; end
          3: begin
            if (wr_allow && !mprot[wr_addr / 1024]) exp_we = 1; else exp_rej = 1;
            mcnt++;
            if (mcnt == PAGE_MAX) ms = 0;
          end
          default: begin
            if (wr_allow) mprot = wr_data; else exp_rej = 1;
            ms = 0;
          end
        endcase
      end else if (ms != 0) begin
        mgap++;
        if (mgap >= GAP_LIMIT) begin ms = 0; mgap = 0; end
      end
    end
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // per-clock comparison against the model (R11 exclusivity included)
  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (arr_we !== exp_we || wr_reject !== exp_rej || (arr_we && wr_reject)) begin
        n_bad++;
        $display("FAIL %s/R11 model: arr_we=%0b wr_reject=%0b expected %0b %0b",
                 cur_req, arr_we, wr_reject, exp_we, exp_rej);
      end
    end
  end

  task automatic check_out(input logic ew, input logic er, input string req);
    n_cmp++;
    if (arr_we !== ew || wr_reject !== er) begin
      n_bad++;
      $display("FAIL %s: arr_we=%0b wr_reject=%0b expected %0b %0b", req, arr_we, wr_reject, ew, er);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_chk(input logic [12:0] a, input logic [7:0] d, input logic ew, input logic er);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    check_out(ew, er, cur_req);
  endtask

  task automatic unlock(input logic [7:0] cmd);
    wr_chk(13'h1555, 8'hAA, 0, 0);
    wr_chk(13'h0AAA, 8'h55, 0, 0);
    wr_chk(13'h1555, cmd, 0, 0);
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    check_out(0, 0, "R1");
    rst_n = 1'b1;
    idle(1);
    check_out(0, 0, "R1");

    cur_req = "R3";
    wr_chk(13'h0100, 8'h12, 0, 1);
    wr_chk(13'h1554, 8'hAA, 0, 1);

    cur_req = "R2"; unlock(8'hA0);
    cur_req = "R5";
    wr_chk(13'h0000, 8'h01, 1, 0);
    wr_chk(13'h1FFF, 8'h02, 1, 0);
    wr_chk(13'h0C00, 8'h03, 1, 0);

    cur_req = "R10";
    idle(GAP_LIMIT + 1);
    wr_chk(13'h0000, 8'h04, 0, 1);
    unlock(8'hA0);
    idle(GAP_LIMIT - 2);
    wr_chk(13'h0400, 8'h05, 1, 0);
    idle(GAP_LIMIT + 1);
    wr_chk(13'h1555, 8'hAA, 0, 0);
    idle(GAP_LIMIT - 1);
    wr_chk(13'h0AAA, 8'h55, 0, 1);

    cur_req = "R4";
    wr_chk(13'h1555, 8'hAA, 0, 0);
    wr_chk(13'h0AAA, 8'h54, 0, 1);
    wr_chk(13'h0AAA, 8'h55, 0, 1);
    wr_chk(13'h1555, 8'hAA, 0, 0);
    wr_chk(13'h0AAA, 8'h55, 0, 0);
    wr_chk(13'h1555, 8'h80, 0, 1);
    wr_chk(13'h0000, 8'h00, 0, 1);

    cur_req = "R7";
    unlock(8'hC0);
    wr_chk(13'h0123, 8'h05, 0, 0);
    cur_req = "R6";
    unlock(8'hA0);
    wr_chk(13'h03FF, 8'h11, 0, 1);
    wr_chk(13'h0400, 8'h12, 1, 0);
    wr_chk(13'h0800, 8'h13, 0, 1);
    wr_chk(13'h1C00, 8'h14, 1, 0);
    idle(GAP_LIMIT + 1);

    cur_req = "R8";
    wr_allow = 1'b0;
    unlock(8'hA0);
    wr_chk(13'h0400, 8'h21, 0, 1);
    idle(GAP_LIMIT + 1);
    unlock(8'hC0);
    wr_chk(13'h0000, 8'h00, 0, 1);
    wr_allow = 1'b1;
    unlock(8'hA0);
    wr_chk(13'h0000, 8'h22, 0, 1);
    idle(GAP_LIMIT + 1);

    cur_req = "R9";
    unlock(8'hC0);
    wr_chk(13'h0000, 8'h00, 0, 0);
    unlock(8'hA0);
    for (int i = 0; i < PAGE_MAX; i++) wr_chk(13'(i * 200), 8'(i), 1, 0);
    wr_chk(13'h0000, 8'h33, 0, 1);

    cur_req = "R7";
    unlock(8'hC0);
    wr_chk(13'h0AAA, 8'hFF, 0, 0);
    unlock(8'hA0);
    for (int b = 0; b < 8; b++) wr_chk(13'(b * 1024 + 7), 8'h44, 0, 1);
    idle(GAP_LIMIT + 1);

    cur_req = "R1";
    rst_n = 1'b0;
    idle(2);
    check_out(0, 0, "R1");
    rst_n = 1'b1;
    unlock(8'hA0);
    wr_chk(13'h1C00, 8'h55, 1, 0);
    wr_chk(13'h0000, 8'h56, 1, 0);
    idle(GAP_LIMIT + 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule